// File: doc/BRIEF.md
# Ten-sample averager with sign router

The block takes a stream of signed samples over a valid/ready handshake and groups them into frames of ten. At the end of each frame the sum of the ten samples is divided by ten, rounding toward zero, and the resulting mean is placed into a one-entry internal channel. A second process empties that channel. It forwards each mean to one of two output valid/ready streams depending on its sign. Negative means leave unchanged on the negative port. Zero and positive means leave negated on the non-negative port.

Both processes repeat forever. After each frame the accumulator and the sample counter start again from zero. A stall on an output port propagates backwards: the router holds its value, the channel stays full, the averager waits with its finished mean, and the input stops accepting samples. The division is done by a bit-serial sequential divider, so the input is closed for a fixed number of cycles after the tenth sample of every frame.

Top module: `ten_avg_router`

## Requirements
- R1: While reset is held, `smp_ready` is 1 and both `neg_valid` and `nn_valid` are 0.
- R2: A sample is taken on every clock edge where `smp_valid` and `smp_ready` are both 1. Each group of ten taken samples produces exactly one output transfer, and results leave in frame order.
- R3: The mean is the signed sum of the ten samples divided by ten, truncated toward zero. A sum of -15 gives -1 and a sum of -9 gives 0.
- R4: A mean below zero is sent on the negative port (`neg_valid`/`neg_data`) with its value unchanged.
- R5: A mean of zero or above is sent on the non-negative port (`nn_valid`/`nn_data`) as its two's-complement negation, so zero leaves as 0 on that port.
- R6: Ten full-scale samples of either sign produce the correct mean with no overflow: ten samples of +32767 give -32767 on the non-negative port, and ten samples of -32768 give -32768 on the negative port.
- R7: `smp_ready` is 0 in the cycle after the tenth sample of a frame is taken. It stays 0 while the finished mean cannot enter the full one-entry channel.
- R8: An output whose valid is 1 while its ready is 0 keeps valid at 1 and its data unchanged in the next cycle.
- R9: Each frame starts from a cleared sum and count, so a result depends only on that frame's ten samples.
- R10: `neg_valid` and `nn_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | SAMPLE_W | Signed input sample |
| smp_valid | input | 1 | Input sample present |
| smp_ready | output | 1 | Block can take a sample |
| neg_data | output | SAMPLE_W | Negative mean, unchanged |
| neg_valid | output | 1 | Negative-port result present |
| neg_ready | input | 1 | Negative-port consumer accepts |
| nn_data | output | SAMPLE_W | Negated zero-or-positive mean |
| nn_valid | output | 1 | Non-negative-port result present |
| nn_ready | input | 1 | Non-negative-port consumer accepts |

## Verification
Small rising and falling frames separate the two routes and test the negation. Frames summing to -15, +15, +9 and -9 distinguish truncation toward zero from floor rounding, and they confirm that a mean of exactly zero takes the non-negative route. Full-scale frames of both signs test the accumulator guard bits. Random samples under random output back-pressure test hold-and-stable behaviour and frame ordering. Holding both output readies low for three frames fills the router, the channel and the averager, and shows that the input closes.

// File: rtl/ten_avg_router.sv
module ten_avg_router #(
  parameter int SAMPLE_W = 16,
  parameter int FRAME_N  = 10,
  parameter int GUARD_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_valid,
  output logic                smp_ready,
  output logic [SAMPLE_W-1:0] neg_data,
  output logic                neg_valid,
  input  logic                neg_ready,
  output logic [SAMPLE_W-1:0] nn_data,
  output logic                nn_valid,
  input  logic                nn_ready
);

  localparam int ACC_W  = SAMPLE_W + GUARD_W;
  localparam int CNT_W  = $clog2(FRAME_N);
  localparam int REM_W  = $clog2(FRAME_N) + 1;
  localparam int STEP_W = $clog2(ACC_W);

  typedef enum logic [1:0] {ST_SUM, ST_DIV, ST_PUT} avg_st_t;

  avg_st_t            st;
  logic [ACC_W-1:0]   acc;
  logic [CNT_W-1:0]   cnt;
  logic [ACC_W-1:0]   quo;
  logic [REM_W-1:0]   rem;
  logic [STEP_W-1:0]  step;
  logic               res_neg;

  logic               ch_full;
  logic [SAMPLE_W-1:0] ch_val;

  logic               o_full;
  logic               o_neg;
  logic [SAMPLE_W-1:0] o_val;

  logic [ACC_W-1:0]   smp_ext;
  logic [ACC_W-1:0]   acc_sum;
  logic [ACC_W-1:0]   sum_mag;
  logic [REM_W-1:0]   rem_sh;
  logic               rem_ge;
  logic [ACC_W-1:0]   mean;
  logic               take;
  logic               last_smp;
  logic               ch_wr;
  logic               ch_pop;
  logic               o_fire;

  assign smp_ready = (st == ST_SUM);
  assign take      = smp_valid && smp_ready;
  assign last_smp  = (cnt == CNT_W'(FRAME_N - 1));
  assign smp_ext   = {{GUARD_W{smp_data[SAMPLE_W-1]}}, smp_data};
  assign acc_sum   = acc + smp_ext;
  assign sum_mag   = acc_sum[ACC_W-1] ? (~acc_sum + 1'b1) : acc_sum;

  assign rem_sh    = {rem[REM_W-2:0], quo[ACC_W-1]};
  assign rem_ge    = (rem_sh >= REM_W'(FRAME_N));
  assign mean      = res_neg ? (~quo + 1'b1) : quo;

  assign ch_wr     = (st == ST_PUT) && !ch_full;
  assign ch_pop    = ch_full && !o_full;
  assign o_fire    = o_full && (o_neg ? neg_ready : nn_ready);

  assign neg_valid = o_full && o_neg;
  assign nn_valid  = o_full && !o_neg;
  assign neg_data  = o_val;
  assign nn_data   = o_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_SUM;
      acc     <= '0;
      cnt     <= '0;
      quo     <= '0;
      rem     <= '0;
      step    <= '0;
      res_neg <= 1'b0;
    end else begin
      unique case (st)
        ST_SUM: begin
          if (take) begin
            if (last_smp) begin
              quo     <= sum_mag;
              res_neg <= acc_sum[ACC_W-1];
              rem     <= '0;
              step    <= '0;
              acc     <= '0;
              cnt     <= '0;
              st      <= ST_DIV;
            end else begin
              acc <= acc_sum;
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DIV: begin
          rem  <= rem_ge ? (rem_sh - REM_W'(FRAME_N)) : rem_sh;
          quo  <= {quo[ACC_W-2:0], rem_ge};
          step <= step + 1'b1;
          if (step == STEP_W'(ACC_W - 1)) st <= ST_PUT;
        end
        ST_PUT: begin
          if (!ch_full) st <= ST_SUM;
        end
        default: st <= ST_SUM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_full <= 1'b0;
      ch_val  <= '0;
    end else if (ch_wr) begin
      ch_full <= 1'b1;
      ch_val  <= mean[SAMPLE_W-1:0];
    end else if (ch_pop) begin
      ch_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_full <= 1'b0;
      o_neg  <= 1'b0;
      o_val  <= '0;
    end else if (ch_pop) begin
      o_full <= 1'b1;
      o_neg  <= ch_val[SAMPLE_W-1];
      o_val  <= ch_val[SAMPLE_W-1] ? ch_val : (~ch_val + 1'b1);
    end else if (o_fire) begin
      o_full <= 1'b0;
    end
  end

endmodule

// File: rtl/ten_avg_router_chk.sv
module ten_avg_router_chk #(
  parameter int SAMPLE_W = 16,
  parameter int FRAME_N  = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [SAMPLE_W-1:0] neg_data,
  input logic                neg_valid,
  input logic                neg_ready,
  input logic [SAMPLE_W-1:0] nn_data,
  input logic                nn_valid,
  input logic                nn_ready
);

  localparam int CW = $clog2(FRAME_N);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (smp_valid && smp_ready)
      seen <= (seen == CW'(FRAME_N - 1)) ? '0 : seen + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (smp_ready && !neg_valid && !nn_valid));

  a_r7_closed_after_tenth: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && seen == CW'(FRAME_N - 1)) |=> !smp_ready);

  a_r8_neg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_valid && !neg_ready) |=> (neg_valid && $stable(neg_data)));

  a_r8_nn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nn_valid && !nn_ready) |=> (nn_valid && $stable(nn_data)));

  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(neg_valid && nn_valid));

  a_r4_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
    neg_valid |-> neg_data[SAMPLE_W-1]);

  a_r5_nn_sign: assert property (@(posedge clk) disable iff (!rst_n)
    nn_valid |-> (nn_data[SAMPLE_W-1] || nn_data == '0));

endmodule

bind ten_avg_router ten_avg_router_chk #(
  .SAMPLE_W(SAMPLE_W),
  .FRAME_N (FRAME_N)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .smp_ready(smp_ready),
  .neg_data (neg_data),
  .neg_valid(neg_valid),
  .neg_ready(neg_ready),
  .nn_data  (nn_data),
  .nn_valid (nn_valid),
  .nn_ready (nn_ready)
);

// File: tb/test_ten_avg_router.sv
`timescale 1ns/1ps
module test_ten_avg_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] neg_data;
  logic        neg_valid;
  logic        neg_ready = 1'b0;
  logic [15:0] nn_data;
  logic        nn_valid;
  logic        nn_ready = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  int ready_mode = 0;
  bit done = 1'b0;

  int exp_val[$];
  bit exp_neg[$];

  bit          prev_neg_stall = 1'b0;
  bit          prev_nn_stall  = 1'b0;
  logic [15:0] prev_neg_data  = '0;
  logic [15:0] prev_nn_data   = '0;

  always #4 clk = ~clk;

  ten_avg_router i_ten_avg_router (
    .clk(clk), .rst_n(rst_n),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .neg_data(neg_data), .neg_valid(neg_valid), .neg_ready(neg_ready),
    .nn_data(nn_data), .nn_valid(nn_valid), .nn_ready(nn_ready)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int v[10]);
    int sum = 0;
    int mean;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 16'(v[i]);
      while (!smp_ready) @(negedge clk);
      sum += v[i];
    end
    @(negedge clk);
    smp_valid = 1'b0;
    if (sum != 0 || 1) begin
      mean = sum / 10;
      if (mean < 0) begin exp_neg.push_back(1'b1); exp_val.push_back(mean); end
      else          begin exp_neg.push_back(1'b0); exp_val.push_back(-mean); end
    end
    // R7: tenth sample taken at the previous edge closes the input
    check("R7", smp_ready == 1'b0, int'(smp_ready), 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_val.size() != 0; i++) @(negedge clk);
    check("R2", exp_val.size() == 0, exp_val.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (ready_mode)
        0: begin neg_ready = 1'b1; nn_ready = 1'b1; end
        1: begin neg_ready = 1'($urandom % 2); nn_ready = 1'($urandom % 2); end
        default: begin neg_ready = 1'b0; nn_ready = 1'b0; end
      endcase
      if (prev_neg_stall)
        check("R8", neg_valid && neg_data == prev_neg_data, int'($signed(neg_data)), int'($signed(prev_neg_data)));
      if (prev_nn_stall)
        check("R8", nn_valid && nn_data == prev_nn_data, int'($signed(nn_data)), int'($signed(prev_nn_data)));
      if (neg_valid && nn_valid) check("R10", 1'b0, 1, 0);
      if (neg_valid && neg_ready) begin
        if (exp_val.size() == 0) check("R2", 1'b0, int'($signed(neg_data)), 0);
        else begin
          check("R4", exp_neg[0] == 1'b1 && int'($signed(neg_data)) == exp_val[0],
                int'($signed(neg_data)), exp_val[0]);
          void'(exp_val.pop_front()); void'(exp_neg.pop_front());
        end
      end
      if (nn_valid && nn_ready) begin
        if (exp_val.size() == 0) check("R2", 1'b0, int'($signed(nn_data)), 0);
        else begin
          check("R5", exp_neg[0] == 1'b0 && int'($signed(nn_data)) == exp_val[0],
                int'($signed(nn_data)), exp_val[0]);
          void'(exp_val.pop_front()); void'(exp_neg.pop_front());
        end
      end
      prev_neg_stall = neg_valid && !neg_ready;
      prev_nn_stall  = nn_valid && !nn_ready;
      prev_neg_data  = neg_data;
      prev_nn_data   = nn_data;
    end
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", exp_val.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int fr[10];
    bit closed;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", smp_ready && !neg_valid && !nn_valid, {smp_ready, neg_valid, nn_valid}, 3'b100);
    rst_n = 1'b1;

    ready_mode = 0;
    send_frame('{1, 2, 3, 4, 5, 6, 7, 8, 9, 10});                  // R5: mean 5 -> -5
    send_frame('{-1, -2, -3, -4, -5, -6, -7, -8, -9, -10});        // R4, R9: mean -5
    send_frame('{-15, 0, 0, 0, 0, 0, 0, 0, 0, 0});                 // R3: -1, not -2
    send_frame('{15, 0, 0, 0, 0, 0, 0, 0, 0, 0});                  // R3: 1 -> -1
    send_frame('{9, 0, 0, 0, 0, 0, 0, 0, 0, 0});                   // R5: zero on nn port
    send_frame('{-9, 0, 0, 0, 0, 0, 0, 0, 0, 0});                  // R3: truncates to 0
    for (int i = 0; i < 10; i++) fr[i] = 32767;
    send_frame(fr);                                                 // R6
    for (int i = 0; i < 10; i++) fr[i] = -32768;
    send_frame(fr);                                                 // R6
    drain();

    ready_mode = 1;                                                 // R8 under back-pressure
    for (int f = 0; f < 20; f++) begin
      for (int i = 0; i < 10; i++) fr[i] = int'($signed(16'($urandom)));
      send_frame(fr);
    end
    drain();

    ready_mode = 2;                                                 // R7: fill everything
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 10; i++) fr[i] = (f + 1) * 100 * ((i % 2) ? 1 : -3);
      send_frame(fr);
    end
    repeat (40) @(negedge clk);
    closed = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (smp_ready) closed = 1'b0;
    end
    check("R7", closed, int'(!closed), 0);
    ready_mode = 0;
    send_frame('{50, 50, 50, 50, 50, 50, 50, 50, 50, 51});
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule